// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Refresh Sequencer

This block keeps a 10-row by 20-column LED array lit by scanning it one row at a time. The array is made of eight 5x5 character cells arranged as two banks of four. The top bank covers rows 0 to 4 and the bottom bank covers rows 5 to 9. While a row is enabled, the block presents the 20 column bits of that row's slice through the four cells of its bank.

The timing source is either a single-cycle internal oscillator pulse or the rising edges of an external clock pin. The external clock pin is synchronised before use. Several displays that share this pin stay in step, so their blinking stays in step too. A prescaler turns source ticks into row steps. Two further divider stages count completed frames and flip a blink phase. A cell whose flash bit is set goes dark while the blink phase is off.

The glyph contents sit outside the block. For every row, the block drives four lookups (7-bit code, page bit, glyph row) and receives five column bits per lookup in the same cycle.

The scan controller has two states:
- `ST_BLANK`: every row enable and every column is off.
- `ST_DRIVE`: one row enable is on and the columns carry data.

Its transitions are:
- "light", `ST_BLANK` to `ST_DRIVE`: taken on the next source tick.
- "step", `ST_DRIVE` to `ST_BLANK`: taken on the prescaler's last tick. This transition also advances the row.
- "restart", any state to `ST_BLANK`: taken on a soft reset.

Top module: `dms_refresh_seq`

## Requirements
- R1: After reset, and until the first source tick, every bit of `row_en_o` and `col_o` is 0.
- R2: At most one bit of `row_en_o` is set at any time. Counting source ticks t since reset, the lit row is (t div PRESCALE) mod 10. The bit for row r is `row_en_o[r]`.
- R3: The first source tick of each row period is dark, with `row_en_o` and `col_o` both 0. The remaining PRESCALE-1 ticks of the period drive the row. Rows never hand over without this dark tick.
- R4: With `clk_sel_i`=1, each cycle where `osc_tick_i`=1 is one source tick, and `ext_clk_i` is ignored. With `clk_sel_i`=0, each synchronised rising edge of `ext_clk_i` is one source tick, and `osc_tick_i` is ignored.
- R5: For lit row r, every lookup uses glyph row r mod 5. Slot n of the lookup port presents the code of cell 4*(r div 5)+n. That cell is byte k=4*(r div 5)+n of `char_codes_i`, located at bits [8k+7:8k]. Bits [6:0] of the byte go out as the code at `glyph_code_o[7n+6:7n]`, and bit 7 goes out as the page at `glyph_page_o[n]`.
- R6: While a row is driven, `col_o[5n+4:5n]` equals `glyph_cols_i[5n+4:5n]`, unless R7 applies.
- R7: The blink phase starts on. It flips each time PRESCALE*10*MID_DIV*BLINK_DIV source ticks have elapsed. While it is off, a cell k with `flash_i[k]`=1 drives its five column bits to 0.
- R8: A one-cycle `soft_rst_i` returns the block to the after-reset state: row 0, dark tick first, blink phase on. Counting of t then restarts from 0.
- R9: Blanking a flashing cell leaves the column bits of the non-flashing cells in the same bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous restart pulse from the write side |
| clk_sel_i | input | 1 | 1: internal oscillator pulses, 0: external clock pin |
| osc_tick_i | input | 1 | Internal oscillator tick, one cycle wide |
| ext_clk_i | input | 1 | External timing clock, asynchronous |
| char_codes_i | input | 64 | Eight cell bytes; byte k at [8k+7:8k], bit 7 page, bits 6:0 code |
| flash_i | input | 8 | Per-cell flash enable |
| glyph_code_o | output | 28 | Four 7-bit lookup codes, slot n at [7n+6:7n] |
| glyph_page_o | output | 4 | Lookup page per slot |
| glyph_row_o | output | 3 | Glyph row (0 to 4) for all slots |
| glyph_cols_i | input | 20 | Lookup results, slot n at [5n+4:5n] |
| row_en_o | output | 10 | One-hot row enable |
| col_o | output | 20 | Column data for the lit row |

## Verification
A prescaler or row counter that drifts shows at the ports within one row period. The lit row bit appears at the wrong index, or the dark tick lands at the wrong place. The bench compares every cycle against a tick-count model, so such a fault is caught within PRESCALE ticks. A blink divider that is off by even one frame stays hidden until the first phase flip, which takes PRESCALE*10*MID_DIV*BLINK_DIV ticks. After that point, flashing cells light or go dark a frame early or late. The bench therefore runs several full blink phases, and it restarts the block through `soft_rst_i` while the phase is off. A wrong bank or slot decode shows at once on `glyph_code_o` and on the column slices.

// File: rtl/dms_pkg.sv
package dms_pkg;
    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_DRIVE = 1'b1
    } scan_state_e;
endpackage

// File: rtl/dms_clk_select.sv
module dms_clk_select #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel_i,
    input  logic osc_tick_i,
    input  logic ext_clk_i,
    output logic src_tick_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] ext_sh_q;
    logic            ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_sh_q <= '0;
        else        ext_sh_q <= {ext_sh_q[SH_W-2:0], ext_clk_i};
    end

    assign ext_rise   = ext_sh_q[SH_W-2] & ~ext_sh_q[SH_W-1];
    assign src_tick_o = clk_sel_i ? osc_tick_i : ext_rise;

    // With the external pin selected, ticks are edge pulses and never last two cycles.
    assert_ext_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_sel_i && $past(!clk_sel_i) && src_tick_o) |=> !(src_tick_o && !clk_sel_i));
endmodule

// File: rtl/dms_scan_ctrl.sv
module dms_scan_ctrl
    import dms_pkg::*;
#(
    parameter int PRESCALE  = 32,
    parameter int ROWS      = 10,
    parameter int ROW_W     = 4,
    parameter int MID_DIV   = 7,
    parameter int BLINK_DIV = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             src_tick_i,
    output logic [ROW_W-1:0] row_o,
    output scan_state_e      state_o,
    output logic             blink_on_o
);
    localparam int PW = (PRESCALE  > 1) ? $clog2(PRESCALE)  : 1;
    localparam int MW = (MID_DIV   > 1) ? $clog2(MID_DIV)   : 1;
    localparam int BW = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;

    scan_state_e      state_q, state_d;
    logic [PW-1:0]    presc_q;
    logic [ROW_W-1:0] row_q;
    logic [MW-1:0]    mid_q;
    logic [BW-1:0]    blk_q;
    logic             blink_on_q;
    logic             scan_tick, frame_wrap, mid_wrap, blink_wrap;

    assign scan_tick  = src_tick_i && (presc_q == PW'(PRESCALE - 1));
    assign frame_wrap = scan_tick  && (row_q == ROW_W'(ROWS - 1));
    assign mid_wrap   = frame_wrap && (mid_q == MW'(MID_DIV - 1));
    assign blink_wrap = mid_wrap   && (blk_q == BW'(BLINK_DIV - 1));

    // next-state: light on a source tick, step on the last prescaler tick
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: if (src_tick_i) state_d = ST_DRIVE;
            ST_DRIVE: if (scan_tick)  state_d = ST_BLANK;
            default:  state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state_q <= ST_BLANK;
        else if (soft_rst_i) state_q <= ST_BLANK;
        else                 state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q    <= '0;
            row_q      <= '0;
            mid_q      <= '0;
            blk_q      <= '0;
            blink_on_q <= 1'b1;
        end else if (soft_rst_i) begin
            presc_q    <= '0;
            row_q      <= '0;
            mid_q      <= '0;
            blk_q      <= '0;
            blink_on_q <= 1'b1;
        end else begin
            if (src_tick_i) presc_q <= scan_tick ? '0 : presc_q + 1'b1;
            if (scan_tick)  row_q   <= frame_wrap ? '0 : row_q + 1'b1;
            if (frame_wrap) mid_q   <= mid_wrap ? '0 : mid_q + 1'b1;
            if (mid_wrap)   blk_q   <= blink_wrap ? '0 : blk_q + 1'b1;
            if (blink_wrap) blink_on_q <= ~blink_on_q;
        end
    end

    assign row_o      = row_q;
    assign state_o    = state_q;
    assign blink_on_o = blink_on_q;

    assert_row_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        row_q < ROW_W'(ROWS));
    // the row only moves on entry to the dark state
    assert_row_moves_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_q) |-> (state_q == ST_BLANK));
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (row_q == '0) && blink_on_q && (state_q == ST_BLANK));
    // the blink phase flips only at the start of a frame
    assert_blink_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blink_on_q) |-> ((row_q == '0) && (state_q == ST_BLANK)));
endmodule

// File: rtl/dms_col_build.sv
module dms_col_build #(
    parameter int DIGITS  = 8,
    parameter int GROUPS  = 2,
    parameter int GLYPH_W = 5,
    parameter int GLYPH_H = 5,
    parameter int CODE_W  = 7,
    parameter int ROW_W   = 4
) (
    input  logic [ROW_W-1:0]                       row_i,
    input  logic                                   blink_on_i,
    input  logic [DIGITS*(CODE_W+1)-1:0]           char_codes_i,
    input  logic [DIGITS-1:0]                      flash_i,
    output logic [(DIGITS/GROUPS)*CODE_W-1:0]      glyph_code_o,
    output logic [DIGITS/GROUPS-1:0]               glyph_page_o,
    output logic [$clog2(GLYPH_H)-1:0]             glyph_row_o,
    input  logic [(DIGITS/GROUPS)*GLYPH_W-1:0]     glyph_cols_i,
    output logic [(DIGITS/GROUPS)*GLYPH_W-1:0]     col_o
);
    localparam int DPG   = DIGITS / GROUPS;
    localparam int GRW   = $clog2(GLYPH_H);
    localparam int IW    = $clog2(DIGITS);
    localparam int ENT_W = CODE_W + 1;

    logic [ROW_W-1:0] grp, grow;

    always_comb begin
        grp  = row_i / ROW_W'(GLYPH_H);
        grow = row_i - grp * ROW_W'(GLYPH_H);
    end

    assign glyph_row_o = grow[GRW-1:0];

    for (genvar n = 0; n < DPG; n++) begin : g_slot
        logic [IW-1:0]    idx;
        logic [ENT_W-1:0] ent;
        logic             dark;

        assign idx  = IW'(grp) * IW'(DPG) + IW'(n);
        assign ent  = char_codes_i[idx * ENT_W +: ENT_W];
        assign dark = flash_i[idx] & ~blink_on_i;

        assign glyph_code_o[n*CODE_W +: CODE_W]  = ent[CODE_W-1:0];
        assign glyph_page_o[n]                   = ent[CODE_W];
        assign col_o[n*GLYPH_W +: GLYPH_W]       = dark ? '0 : glyph_cols_i[n*GLYPH_W +: GLYPH_W];
    end
endmodule

// File: rtl/dms_refresh_seq.sv
module dms_refresh_seq
    import dms_pkg::*;
#(
    parameter int DIGITS    = 8,
    parameter int GROUPS    = 2,
    parameter int GLYPH_W   = 5,
    parameter int GLYPH_H   = 5,
    parameter int CODE_W    = 7,
    parameter int PRESCALE  = 32,
    parameter int MID_DIV   = 7,
    parameter int BLINK_DIV = 128
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  soft_rst_i,
    input  logic                                  clk_sel_i,
    input  logic                                  osc_tick_i,
    input  logic                                  ext_clk_i,
    input  logic [DIGITS*(CODE_W+1)-1:0]          char_codes_i,
    input  logic [DIGITS-1:0]                     flash_i,
    output logic [(DIGITS/GROUPS)*CODE_W-1:0]     glyph_code_o,
    output logic [DIGITS/GROUPS-1:0]              glyph_page_o,
    output logic [$clog2(GLYPH_H)-1:0]            glyph_row_o,
    input  logic [(DIGITS/GROUPS)*GLYPH_W-1:0]    glyph_cols_i,
    output logic [GROUPS*GLYPH_H-1:0]             row_en_o,
    output logic [(DIGITS/GROUPS)*GLYPH_W-1:0]    col_o
);
    localparam int ROWS  = GROUPS * GLYPH_H;
    localparam int DPG   = DIGITS / GROUPS;
    localparam int COLS  = DPG * GLYPH_W;
    localparam int ROW_W = $clog2(ROWS);

    logic             src_tick;
    logic [ROW_W-1:0] row;
    scan_state_e      state;
    logic             blink_on;
    logic [COLS-1:0]  cols_built;

    dms_clk_select #(.SYNC_STAGES(2)) u_clk_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel_i  (clk_sel_i),
        .osc_tick_i (osc_tick_i),
        .ext_clk_i  (ext_clk_i),
        .src_tick_o (src_tick)
    );

    dms_scan_ctrl #(
        .PRESCALE  (PRESCALE),
        .ROWS      (ROWS),
        .ROW_W     (ROW_W),
        .MID_DIV   (MID_DIV),
        .BLINK_DIV (BLINK_DIV)
    ) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst_i),
        .src_tick_i (src_tick),
        .row_o      (row),
        .state_o    (state),
        .blink_on_o (blink_on)
    );

    dms_col_build #(
        .DIGITS  (DIGITS),
        .GROUPS  (GROUPS),
        .GLYPH_W (GLYPH_W),
        .GLYPH_H (GLYPH_H),
        .CODE_W  (CODE_W),
        .ROW_W   (ROW_W)
    ) u_cols (
        .row_i        (row),
        .blink_on_i   (blink_on),
        .char_codes_i (char_codes_i),
        .flash_i      (flash_i),
        .glyph_code_o (glyph_code_o),
        .glyph_page_o (glyph_page_o),
        .glyph_row_o  (glyph_row_o),
        .glyph_cols_i (glyph_cols_i),
        .col_o        (cols_built)
    );

    // output process: dark in ST_BLANK, one row plus data in ST_DRIVE
    always_comb begin
        row_en_o = '0;
        col_o    = '0;
        unique case (state)
            ST_BLANK: begin
                row_en_o = '0;
                col_o    = '0;
            end
            ST_DRIVE: begin
                row_en_o = ROWS'(1) << row;
                col_o    = cols_built;
            end
            default: ;
        endcase
    end

    assert_onehot_rows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en_o));
    assert_no_direct_handover_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en_o != '0) |=> (row_en_o == '0) || (row_en_o == $past(row_en_o)));
    assert_dark_cols_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en_o == '0) |-> (col_o == '0));

    for (genvar d = 0; d < DIGITS; d++) begin : g_flash_chk
        localparam int GRP  = d / DPG;
        localparam int SLOT = d % DPG;
        assert_flash_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((row / ROW_W'(GLYPH_H)) == ROW_W'(GRP) && flash_i[d] && !blink_on)
                |-> (col_o[SLOT*GLYPH_W +: GLYPH_W] == '0));
    end
endmodule

// File: tb/dms_refresh_seq_tb.sv
module dms_refresh_seq_tb;
    localparam int P   = 4;
    localparam int MID = 3;
    localparam int BLK = 2;
    localparam int PHASE = P * 10 * MID * BLK;
    localparam int NV  = 4;

    // stimulus table: cell bytes, flash mask, cycles, oscillator every other cycle
    localparam logic [63:0] TBL_CODES [NV] = '{64'h4142_4344_4546_4748,
                                               64'hC135_7A20_9FE3_0D66,
                                               64'hFF00_AA55_1234_8081,
                                               64'h7E81_3CC3_5AA5_0FF0};
    localparam logic [7:0]  TBL_FLASH [NV] = '{8'h00, 8'hA5, 8'hF0, 8'h0F};
    localparam int          TBL_LEN   [NV] = '{300, 320, 400, 300};
    localparam bit          TBL_GAP   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        clk_sel = 1'b1;
    logic        osc_tick = 1'b0;
    logic        ext_clk = 1'b0;
    logic [63:0] codes = '0;
    logic [7:0]  flash = '0;
    logic [27:0] g_code;
    logic [3:0]  g_page;
    logic [2:0]  g_row;
    logic [19:0] g_cols;
    logic [9:0]  row_en;
    logic [19:0] cols;

    int t = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dms_refresh_seq #(.PRESCALE(P), .MID_DIV(MID), .BLINK_DIV(BLK)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst),
        .clk_sel_i    (clk_sel),
        .osc_tick_i   (osc_tick),
        .ext_clk_i    (ext_clk),
        .char_codes_i (codes),
        .flash_i      (flash),
        .glyph_code_o (g_code),
        .glyph_page_o (g_page),
        .glyph_row_o  (g_row),
        .glyph_cols_i (g_cols),
        .row_en_o     (row_en),
        .col_o        (cols)
    );

    function automatic logic [4:0] glyph(input logic [6:0] c, input logic pg, input logic [2:0] r);
        return c[4:0] ^ {pg, r, 1'b1};
    endfunction

    // glyph lookup model on the lookup port
    always_comb begin
        for (int n = 0; n < 4; n++)
            g_cols[n*5 +: 5] = glyph(g_code[n*7 +: 7], g_page[n], g_row);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0d)", tag, act, exp, t);
        end
    endtask

    task automatic compare_all(input string ctx);
        int presc, row, grp, idx;
        bit drv, bon, any_dark;
        logic [9:0] er;
        logic [7:0] ent;
        logic [4:0] g;
        presc = t % P;
        row   = (t / P) % 10;
        grp   = row / 5;
        drv   = (presc != 0);
        bon   = ((t / PHASE) % 2) == 0;
        er    = drv ? (10'd1 << row) : 10'd0;
        check({ctx, drv ? " R2 row" : " R3 dark row"}, 32'(row_en), 32'(er));
        check({ctx, " R5 glyph row"}, 32'(g_row), 32'(row % 5));
        any_dark = 1'b0;
        for (int n = 0; n < 4; n++) if (flash[grp*4+n] && !bon) any_dark = 1'b1;
        for (int n = 0; n < 4; n++) begin
            idx = grp * 4 + n;
            ent = codes[idx*8 +: 8];
            check({ctx, " R5 code"}, 32'({g_page[n], g_code[n*7 +: 7]}), 32'(ent));
            g = glyph(ent[6:0], ent[7], 3'(row % 5));
            if (flash[idx] && !bon) g = '0;
            if (!drv) g = '0;
            if (!drv)
                check({ctx, " R3 dark cols"}, 32'(cols[n*5 +: 5]), 32'(g));
            else if (flash[idx] && !bon)
                check({ctx, " R7 flash"}, 32'(cols[n*5 +: 5]), 32'(g));
            else if (any_dark)
                check({ctx, " R9 neighbour"}, 32'(cols[n*5 +: 5]), 32'(g));
            else
                check({ctx, " R6 cols"}, 32'(cols[n*5 +: 5]), 32'(g));
        end
    endtask

    // one cycle: compare at the falling edge, then set inputs for the next rising edge
    task automatic cycle(input logic osc, input logic ext, input logic srst, input bit cmp, input string ctx);
        @(negedge clk);
        if (cmp) compare_all(ctx);
        osc_tick = osc;
        ext_clk  = ext;
        soft_rst = srst;
        if (srst) t = 0;
        else if (clk_sel && osc) t++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rows", 32'(row_en), 32'd0);
        check("R1 reset cols", 32'(cols), 32'd0);
        rst_n = 1'b1;
        codes = TBL_CODES[0];
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, 1'b0, 1'b0, 1'b0, "");
            check("R1 idle rows", 32'(row_en), 32'd0);
            check("R1 idle cols", 32'(cols), 32'd0);
        end

        // table walk with the internal oscillator; ext_clk toggles and must be ignored (R4)
        for (int v = 0; v < NV; v++) begin
            codes = TBL_CODES[v];
            flash = TBL_FLASH[v];
            for (int c = 0; c < TBL_LEN[v]; c++)
                cycle(TBL_GAP[v] ? logic'(c % 2) : 1'b1, logic'((c >> 2) & 1), 1'b0, 1'b1, "table R4");
        end

        // restart while the blink phase is off (R8)
        flash = 8'hFF;
        while (((t / PHASE) % 2) == 0) cycle(1'b1, 1'b0, 1'b0, 1'b1, "pre R8");
        repeat (20) cycle(1'b1, 1'b0, 1'b0, 1'b1, "off R7");
        cycle(1'b0, 1'b0, 1'b1, 1'b1, "R8 pulse");
        repeat (60) cycle(1'b1, 1'b0, 1'b0, 1'b1, "after R8");

        // external clock mode (R4)
        repeat (4) cycle(1'b0, 1'b0, 1'b0, 1'b1, "settle R4");
        @(negedge clk);
        clk_sel = 1'b0;
        cycle(1'b0, 1'b0, 1'b1, 1'b0, "");
        for (int c = 0; c < 10; c++) cycle(logic'(c % 2 == 0), 1'b0, 1'b0, 1'b1, "R4 osc ignored");
        for (int k = 1; k <= 14; k++) begin
            repeat (4) cycle(1'b1, 1'b1, 1'b0, 1'b0, "");
            repeat (4) cycle(1'b1, 1'b0, 1'b0, 1'b0, "");
            t = k;
            cycle(1'b0, 1'b0, 1'b0, 1'b1, "R4 ext edge");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule